// File: doc/BRIEF.md
# Invalidation Acknowledgement Collector

This block decides when a store that needs ownership has actually finished on an interconnect that may deliver messages in any order. Each write miss or upgrade arrives with the directory's sharer vector for its line. The block puts the request in a free tracking slot and returns that slot number as the transaction id. One cycle later it emits a multicast invalidation with the same slot number and the sharer mask. It then clears one sharer bit for each acknowledgement that names the slot and the responding node. A store is reported complete only when every sharer has answered, because only then can no stale copy remain anywhere.

Each slot runs a three-state machine. SLOT_FREE moves to SLOT_WAIT on allocation with a non-empty mask, or directly to SLOT_REPORT when the mask is empty. SLOT_WAIT moves to SLOT_REPORT when the last pending sharer acknowledges. SLOT_REPORT moves back to SLOT_FREE in the cycle its completion is presented on the done port. Of the slots in SLOT_REPORT, the lowest-numbered one is presented first.

A coarse-grained barrier tracker has two states, BAR_IDLE and BAR_HOLD. BAR_IDLE moves to BAR_HOLD on a barrier request and captures the set of slots occupied at that moment. BAR_HOLD removes each captured slot as it reports, and it returns to BAR_IDLE one cycle after it signals barrier completion. A barrier therefore retires only when all writes allocated before it have been fully acknowledged.

Top module: `ack_collector`

## Requirements
- R1: After reset all slots are free: `req_ready` is 1, `req_slot` is 0, `done_valid`, `inv_valid`, `dup_err` and `bar_done` are 0, and `bar_ready` is 1. `req_ready` is 1 exactly when some slot is free, and `req_slot` is the lowest-numbered free slot.
- R2: A request accepted in cycle t (`req_valid` and `req_ready`) with a non-empty sharer vector produces `inv_valid`=1 in cycle t+1. In that cycle `inv_slot` equals the granted slot and `inv_mask` equals the sharer vector. Bit i of the mask means node i.
- R3: A request accepted in cycle t with an all-zero sharer vector produces no invalidation. Its completion is presented in cycle t+1 if no lower slot is reporting.
- R4: An acknowledgement carries a slot number and a node number. A valid acknowledgement that clears the last pending sharer of a slot in cycle t makes `done_valid`=1 with `done_slot` equal to that slot in cycle t+1. Before that point the slot is never reported.
- R5: Each completion is presented for exactly one cycle, and the slot is free again in the following cycle. When several slots are complete at once, the lowest-numbered one is presented first.
- R6: An acknowledgement that names a node no longer pending, a node outside the vector, or a slot that is not waiting changes no slot state. It makes `dup_err`=1 in the following cycle.
- R7: When all slots are busy, `req_ready` is 0. A request made then is refused and produces no invalidation.
- R8: A `bar_req` accepted in BAR_IDLE in cycle t captures the slots that are occupied and not retiring in cycle t. `bar_done` is 1 for one cycle, in the cycle after the last captured slot presents its completion, or in cycle t+1 if none was captured.
- R9: While a barrier is held (BAR_HOLD), `bar_ready` is 0 and any further `bar_req` is ignored. `bar_ready` returns to 1 in the cycle after `bar_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New write miss or upgrade |
| req_sharers | input | NODES | Sharer vector from the directory |
| req_ready | output | 1 | A slot is free |
| req_slot | output | SLOT_W | Slot granted to the request (transaction id) |
| inv_valid | output | 1 | Multicast invalidation this cycle |
| inv_slot | output | SLOT_W | Transaction id of the invalidation |
| inv_mask | output | NODES | Nodes to invalidate |
| ack_valid | input | 1 | Acknowledgement arrives |
| ack_slot | input | SLOT_W | Transaction id of the acknowledgement |
| ack_node | input | NODE_W | Responding node |
| done_valid | output | 1 | A store may retire |
| done_slot | output | SLOT_W | Transaction id that completed |
| dup_err | output | 1 | A stray or duplicate acknowledgement was seen last cycle |
| bar_req | input | 1 | Barrier issued |
| bar_ready | output | 1 | Barrier tracker idle |
| bar_done | output | 1 | Barrier may retire |

## Verification
The invalidation and the error flag are registered, so they are due one cycle after the grant or the acknowledgement that causes them. A completion is due one cycle after its last acknowledgement, or one cycle after an empty-vector grant. Barrier completion is due one cycle after the last captured slot presents its completion. The bench drives and samples one time unit after each rising edge and advances exactly one edge between a stimulus and its check. Each expected value is therefore read in the cycle the timing above predicts, never earlier and never later. The sweep covers every sharer vector of a four-node configuration and acknowledges the set nodes in ascending order.

// File: rtl/ackc_pkg.sv
package ackc_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_REPORT = 2'd2
    } slot_state_e;

    typedef enum logic {
        BAR_IDLE = 1'b0,
        BAR_HOLD = 1'b1
    } bar_state_e;
endpackage

// File: rtl/ackc_lowest.sv
module ackc_lowest #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] vec,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/ackc_slot.sv
module ackc_slot
    import ackc_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int NODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [NODES-1:0]  alloc_mask,
    input  logic              ack_hit,
    input  logic [NODE_W-1:0] ack_node,
    input  logic              retire,
    output slot_state_e       state_o,
    output logic              dup_o
);
    slot_state_e      state, nxt_state;
    logic [NODES-1:0] mask, nxt_mask;
    logic             node_ok, hit_pending;

    generate
        if ((1 << NODE_W) == NODES) begin : g_full
            assign node_ok = 1'b1;
        end else begin : g_part
            assign node_ok = ({1'b0, ack_node} < (NODE_W + 1)'(NODES));
        end
    endgenerate

    assign hit_pending = node_ok && mask[ack_node];
    assign state_o     = state;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SLOT_FREE;
            mask  <= '0;
        end else begin
            state <= nxt_state;
            mask  <= nxt_mask;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_mask  = mask;
        dup_o     = 1'b0;
        unique case (state)
            SLOT_FREE: begin
                if (ack_hit) dup_o = 1'b1;
                if (alloc) begin
                    nxt_mask  = alloc_mask;
                    nxt_state = (|alloc_mask) ? SLOT_WAIT : SLOT_REPORT;
                end
            end
            SLOT_WAIT: begin
                if (ack_hit) begin
                    if (hit_pending) begin
                        nxt_mask = mask & ~(NODES'(1) << ack_node);
                        if (nxt_mask == '0) nxt_state = SLOT_REPORT;
                    end else begin
                        dup_o = 1'b1;
                    end
                end
            end
            SLOT_REPORT: begin
                if (ack_hit) dup_o = 1'b1;
                if (retire) nxt_state = SLOT_FREE;
            end
            default: nxt_state = SLOT_FREE;
        endcase
    end
endmodule

// File: rtl/ackc_barrier.sv
module ackc_barrier
    import ackc_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bar_req,
    input  logic [SLOTS-1:0] busy,
    input  logic [SLOTS-1:0] retire,
    output logic             bar_ready,
    output logic             bar_done
);
    bar_state_e       state, nxt_state;
    logic [SLOTS-1:0] pending, nxt_pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= BAR_IDLE;
            pending <= '0;
        end else begin
            state   <= nxt_state;
            pending <= nxt_pending;
        end
    end

    always_comb begin
        nxt_state   = state;
        nxt_pending = pending;
        unique case (state)
            BAR_IDLE: begin
                if (bar_req) begin
                    nxt_pending = busy & ~retire;
                    nxt_state   = BAR_HOLD;
                end
            end
            BAR_HOLD: begin
                nxt_pending = pending & ~retire;
                if (pending == '0) nxt_state = BAR_IDLE;
            end
            default: nxt_state = BAR_IDLE;
        endcase
    end

    assign bar_ready = (state == BAR_IDLE);
    assign bar_done  = (state == BAR_HOLD) && (pending == '0);
endmodule

// File: rtl/ack_collector.sv
module ack_collector
    import ackc_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int NODES  = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NODES-1:0]  req_sharers,
    output logic              req_ready,
    output logic [SLOT_W-1:0] req_slot,
    output logic              inv_valid,
    output logic [SLOT_W-1:0] inv_slot,
    output logic [NODES-1:0]  inv_mask,
    input  logic              ack_valid,
    input  logic [SLOT_W-1:0] ack_slot,
    input  logic [NODE_W-1:0] ack_node,
    output logic              done_valid,
    output logic [SLOT_W-1:0] done_slot,
    output logic              dup_err,
    input  logic              bar_req,
    output logic              bar_ready,
    output logic              bar_done
);
    slot_state_e      st   [SLOTS];
    logic [SLOTS-1:0] free_vec, rep_vec, busy_vec, alloc_vec, retire_vec, dup_vec;
    logic             grant, slot_ok;

    generate
        if ((1 << SLOT_W) == SLOTS) begin : g_full
            assign slot_ok = 1'b1;
        end else begin : g_part
            assign slot_ok = ({1'b0, ack_slot} < (SLOT_W + 1)'(SLOTS));
        end
    endgenerate

    ackc_lowest #(.N(SLOTS), .W(SLOT_W)) u_free_pick (
        .vec(free_vec), .any(req_ready), .idx(req_slot)
    );
    ackc_lowest #(.N(SLOTS), .W(SLOT_W)) u_rep_pick (
        .vec(rep_vec), .any(done_valid), .idx(done_slot)
    );

    assign grant = req_valid && req_ready;

    generate
        for (genvar i = 0; i < SLOTS; i++) begin : g_slot
            assign free_vec[i]   = (st[i] == SLOT_FREE);
            assign rep_vec[i]    = (st[i] == SLOT_REPORT);
            assign busy_vec[i]   = !free_vec[i];
            assign alloc_vec[i]  = grant && (req_slot == SLOT_W'(i));
            assign retire_vec[i] = done_valid && (done_slot == SLOT_W'(i));
            ackc_slot #(.NODES(NODES), .NODE_W(NODE_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc     (alloc_vec[i]),
                .alloc_mask(req_sharers),
                .ack_hit   (ack_valid && slot_ok && (ack_slot == SLOT_W'(i))),
                .ack_node  (ack_node),
                .retire    (retire_vec[i]),
                .state_o   (st[i]),
                .dup_o     (dup_vec[i])
            );
        end
    endgenerate

    ackc_barrier #(.SLOTS(SLOTS)) u_bar (
        .clk      (clk),
        .rst_n    (rst_n),
        .bar_req  (bar_req),
        .busy     (busy_vec),
        .retire   (retire_vec),
        .bar_ready(bar_ready),
        .bar_done (bar_done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_valid <= 1'b0;
            inv_slot  <= '0;
            inv_mask  <= '0;
            dup_err   <= 1'b0;
        end else begin
            inv_valid <= grant && (|req_sharers);
            inv_slot  <= req_slot;
            inv_mask  <= req_sharers;
            dup_err   <= (|dup_vec) || (ack_valid && !slot_ok);
        end
    end
endmodule

// File: rtl/ack_collector_chk.sv
module ack_collector_chk #(
    parameter int SLOTS  = 4,
    parameter int NODES  = 8,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [NODES-1:0]  req_sharers,
    input logic              req_ready,
    input logic [SLOT_W-1:0] req_slot,
    input logic              inv_valid,
    input logic [SLOT_W-1:0] inv_slot,
    input logic [NODES-1:0]  inv_mask,
    input logic              ack_valid,
    input logic              done_valid,
    input logic              dup_err,
    input logic              bar_ready,
    input logic              bar_done
);
    // R2
    inv_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (|req_sharers)) |=>
            (inv_valid && inv_slot == $past(req_slot) && inv_mask == $past(req_sharers)));

    // R7
    no_inv_without_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> $past(req_valid && req_ready));

    // R3
    empty_done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_sharers == '0) |=> done_valid);

    // R5
    slot_freed_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready);

    // R6
    dup_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |-> $past(ack_valid));

    // R9
    bar_ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bar_done |=> (bar_ready && !bar_done));
endmodule

bind ack_collector ack_collector_chk #(.SLOTS(SLOTS), .NODES(NODES)) u_ack_collector_chk (.*);

// File: tb/test_ack_collector.sv
module test_ack_collector;
    localparam int SLOTS = 4;
    localparam int NODES = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic [3:0] req_sharers;
    logic       req_ready;
    logic [1:0] req_slot;
    logic       inv_valid;
    logic [1:0] inv_slot;
    logic [3:0] inv_mask;
    logic       ack_valid;
    logic [1:0] ack_slot;
    logic [1:0] ack_node;
    logic       done_valid;
    logic [1:0] done_slot;
    logic       dup_err;
    logic       bar_req;
    logic       bar_ready;
    logic       bar_done;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ack_collector #(.SLOTS(SLOTS), .NODES(NODES)) i_ack_collector (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic send_ack(input int slot, input int node);
        ack_valid = 1'b1;
        ack_slot  = 2'(slot);
        ack_node  = 2'(node);
        tick();
        ack_valid = 1'b0;
    endtask

    initial begin
        #1900000;
        if (!finished) begin
            errors++;
            vectors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_sharers = '0;
        ack_valid = 1'b0; ack_slot = '0; ack_node = '0; bar_req = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(req_ready && req_slot == 0, "R1", int'(req_ready), 1);
        check(!done_valid && !inv_valid && !dup_err, "R1", int'(done_valid), 0);
        check(bar_ready && !bar_done, "R1", int'(bar_ready), 1);

        // R2 R3 R4 R5: sweep every sharer vector
        for (int p = 0; p < 16; p++) begin
            int last;
            last = -1;
            for (int n = 0; n < NODES; n++) if (p[n]) last = n;
            req_valid = 1'b1; req_sharers = 4'(p);
            check(req_ready && req_slot == 0, "R1", int'(req_slot), 0);
            tick();
            req_valid = 1'b0;
            if (p != 0) begin
                check(inv_valid && inv_slot == 0 && inv_mask == 4'(p), "R2", int'(inv_mask), p);
                check(!done_valid, "R4", int'(done_valid), 0);
                for (int n = 0; n < NODES; n++) begin
                    if (p[n]) begin
                        send_ack(0, n);
                        check(!dup_err, "R6", int'(dup_err), 0);
                        if (n == last)
                            check(done_valid && done_slot == 0, "R4", int'(done_valid), 1);
                        else
                            check(!done_valid, "R4", int'(done_valid), 0);
                    end
                end
            end else begin
                check(!inv_valid, "R3", int'(inv_valid), 0);
                check(done_valid && done_slot == 0, "R3", int'(done_valid), 1);
            end
            tick();
            check(!done_valid && req_ready && req_slot == 0, "R5", int'(done_valid), 0);
        end

        // R6 duplicate and stray acknowledgements
        req_valid = 1'b1; req_sharers = 4'b0011;
        tick();
        req_valid = 1'b0;
        send_ack(0, 0);
        check(!dup_err && !done_valid, "R6", int'(dup_err), 0);
        send_ack(0, 0);
        check(dup_err && !done_valid, "R6", int'(dup_err), 1);
        send_ack(0, 2);
        check(dup_err && !done_valid, "R6", int'(dup_err), 1);
        send_ack(3, 0);
        check(dup_err && !done_valid, "R6", int'(dup_err), 1);
        send_ack(0, 1);
        check(!dup_err && done_valid && done_slot == 0, "R6", int'(done_valid), 1);
        tick();

        // R5 concurrent completions report lowest first
        req_valid = 1'b1; req_sharers = 4'b0001;
        tick();
        tick();
        req_sharers = 4'b0000;
        check(req_slot == 2, "R1", int'(req_slot), 2);
        ack_valid = 1'b1; ack_slot = 2'd1; ack_node = 2'd0;
        tick();
        req_valid = 1'b0; ack_valid = 1'b0;
        check(done_valid && done_slot == 1, "R5", int'(done_slot), 1);
        tick();
        check(done_valid && done_slot == 2, "R5", int'(done_slot), 2);
        tick();
        check(!done_valid, "R5", int'(done_valid), 0);
        send_ack(0, 0);
        check(done_valid && done_slot == 0, "R4", int'(done_slot), 0);
        tick();

        // R7 fill every slot, then a refused request
        req_valid = 1'b1; req_sharers = 4'b0001;
        for (int k = 0; k < SLOTS; k++) begin
            check(req_ready && req_slot == 2'(k), "R1", int'(req_slot), k);
            tick();
        end
        check(!req_ready, "R7", int'(req_ready), 0);
        tick();
        req_valid = 1'b0;
        check(!inv_valid, "R7", int'(inv_valid), 0);

        // R8 R9 barrier over four busy slots
        bar_req = 1'b1;
        tick();
        check(!bar_ready && !bar_done, "R9", int'(bar_ready), 0);
        send_ack(2, 0);
        bar_req = 1'b0;
        check(done_valid && done_slot == 2 && !bar_done, "R8", int'(bar_done), 0);
        tick();
        check(req_ready && req_slot == 2, "R5", int'(req_slot), 2);
        send_ack(0, 0);
        tick();
        send_ack(1, 0);
        tick();
        check(!bar_done, "R8", int'(bar_done), 0);
        send_ack(3, 0);
        check(done_valid && done_slot == 3 && !bar_done, "R8", int'(bar_done), 0);
        tick();
        check(bar_done && !bar_ready, "R8", int'(bar_done), 1);
        tick();
        check(!bar_done && bar_ready, "R9", int'(bar_ready), 1);

        // R8 empty barrier completes next cycle
        bar_req = 1'b1;
        tick();
        bar_req = 1'b0;
        check(bar_done, "R8", int'(bar_done), 1);
        tick();
        check(!bar_done && bar_ready, "R9", int'(bar_done), 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule